// File: doc/BRIEF.md
# Clarke/Park Vector Transform Unit

This block is a small sequential coprocessor for field-oriented motor control. It converts between phase quantities, a stationary two-axis frame and a rotating two-axis frame. It performs four operations: forward Clarke, reverse Clarke, forward Park rotation and reverse Park rotation. All operands and results are 12-bit two's-complement integers. Each operation runs on one shared multiply-accumulate path, one product per clock, and takes the same fixed number of cycles whatever the mode.

A host drives two operands, an angle and a mode, and pulses `start_i`. After a fixed delay `done_o` pulses for one cycle. The three result ports then hold their values until the next operation completes.

The angle is an unsigned fraction of one turn. Its top six bits select one of 64 rotation steps. Sine and cosine come from a 17-entry quarter-wave table scaled by 2047. Every weighted sum is rounded and then saturated, so it never wraps.

Top module: `vx_xform`

## Requirements
- R1: `mode_i` selects the operation: 0 forward Clarke, 1 reverse Clarke, 2 forward Park, 3 reverse Park. The mode, both operands and the angle are captured at the edge that accepts `start_i`.
- R2: Forward Clarke (in0 = a, in1 = b) gives res0 = in0, res1 = rs(1182·in0 + 2364·in1) and res2 = 0.
- R3: Reverse Clarke (in0 = alpha, in1 = beta) gives res0 = in0, res1 = rs(−1024·in0 + 1774·in1) and res2 = rs(−1024·in0 − 1774·in1).
- R4: Let n be angle bits [11:6]. Then S = round(2047·sin(n·π/32)) and C = round(2047·cos(n·π/32)), with ties rounded away from zero. Angle bits [5:0] have no effect on any result.
- R5: Forward Park gives res0 = rs(in0·C + in1·S), res1 = rs(−in0·S + in1·C) and res2 = 0.
- R6: Reverse Park gives res0 = rs(in0·C − in1·S), res1 = rs(in0·S + in1·C) and res2 = 0.
- R7: rs(P) = floor((P + 1024) / 2048), clamped to the range −2048..2047.
- R8: `start_i` is accepted at a rising edge while idle. `done_o` rises six edges after the accepting edge and stays high for exactly one cycle. The result ports change only at the edge where `done_o` rises.
- R9: `busy_o` is high from the accepting edge until `done_o` rises. A `start_i` while busy is ignored: it does not change the timing or the results of the running operation, and it does not start a later one.
- R10: While `rst_ni` is low, `busy_o` and `done_o` are 0 and all result ports are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| mode_i | input | 2 | Operation select (R1 encoding) |
| op0_i | input | 12 | First operand, signed |
| op1_i | input | 12 | Second operand, signed |
| angle_i | input | 12 | Rotation angle, unsigned fraction of a turn |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res0_o | output | 12 | First result, signed |
| res1_o | output | 12 | Second result, signed |
| res2_o | output | 12 | Third result, signed |

## Verification
The assertions watch several properties on every cycle:
- the fixed six-edge spacing from acceptance to `done_o`;
- the one-cycle width of `done_o` and the busy window;
- results that stay stable outside completion;
- the pass-through first result of both Clarke modes;
- the zero third result of the Park modes.

The arithmetic needs the bench's sweeps: a 16×16 operand grid in both Clarke modes, and every one of the 64 angle steps with noise in the ignored angle bits under six operand pairs in both Park modes. Saturation at both rails and a start issued mid-operation are shown only by those scenarios.

// File: rtl/vx_pkg.sv
package vx_pkg;
    // Coefficient format: signed, FRAC fractional bits (unity = 2048)
    localparam int CW        = 13;
    localparam int FRAC      = 11;
    // Schedule: three outputs, two product terms each
    localparam int NOUT      = 3;
    localparam int NSTEP     = 2 * NOUT;
    localparam int STEP_W    = $clog2(NSTEP);
    // Angle quantisation: quarter-wave table index bits plus quadrant
    localparam int TIDX_W    = 4;
    localparam int ANG_IDX_W = TIDX_W + 2;

    typedef enum logic [1:0] {
        XF_CLARKE_FWD = 2'd0,
        XF_CLARKE_REV = 2'd1,
        XF_PARK_FWD   = 2'd2,
        XF_PARK_REV   = 2'd3
    } xf_mode_e;

    typedef logic signed [CW-1:0] coef_t;

    localparam coef_t K_UNIT     = 13'sd2048;  // 1.0
    localparam coef_t K_INV_RT3  = 13'sd1182;  // 1/sqrt(3)
    localparam coef_t K_2INV_RT3 = 13'sd2364;  // 2/sqrt(3)
    localparam coef_t K_HALF     = 13'sd1024;  // 0.5
    localparam coef_t K_RT3_HALF = 13'sd1774;  // sqrt(3)/2
endpackage

// File: rtl/vx_sincos.sv
module vx_sincos
    import vx_pkg::*;
(
    input  logic [ANG_IDX_W-1:0] idx_i,
    output coef_t                sin_o,
    output coef_t                cos_o
);
    // Quarter-wave magnitudes: round(2047 * sin(k*pi/32)), k = 0..16
    function automatic coef_t quarter(input logic [TIDX_W:0] k);
        case (k)
            5'd0:    quarter = 13'sd0;
            5'd1:    quarter = 13'sd201;
            5'd2:    quarter = 13'sd399;
            5'd3:    quarter = 13'sd594;
            5'd4:    quarter = 13'sd783;
            5'd5:    quarter = 13'sd965;
            5'd6:    quarter = 13'sd1137;
            5'd7:    quarter = 13'sd1299;
            5'd8:    quarter = 13'sd1447;
            5'd9:    quarter = 13'sd1582;
            5'd10:   quarter = 13'sd1702;
            5'd11:   quarter = 13'sd1805;
            5'd12:   quarter = 13'sd1891;
            5'd13:   quarter = 13'sd1959;
            5'd14:   quarter = 13'sd2008;
            5'd15:   quarter = 13'sd2037;
            5'd16:   quarter = 13'sd2047;
            default: quarter = 13'sd0;
        endcase
    endfunction

    coef_t wave [2];

    // Phase 0 gives sine; phase 1 is advanced a quarter turn for cosine
    for (genvar g = 0; g < 2; g++) begin : g_phase
        localparam logic [ANG_IDX_W-1:0] OFS = ANG_IDX_W'(g * (1 << TIDX_W));
        logic [ANG_IDX_W-1:0] ph;
        logic [1:0]           quad;
        logic [TIDX_W-1:0]    frac;
        logic [TIDX_W:0]      kk;
        coef_t                mag;

        assign ph   = idx_i + OFS;
        assign quad = ph[ANG_IDX_W-1 -: 2];
        assign frac = ph[TIDX_W-1:0];
        assign kk   = quad[0] ? ((TIDX_W+1)'(1 << TIDX_W) - {1'b0, frac})
                              : {1'b0, frac};
        assign mag  = quarter(kk);
        assign wave[g] = quad[1] ? -mag : mag;
    end

    assign sin_o = wave[0];
    assign cos_o = wave[1];
endmodule

// File: rtl/vx_coef.sv
module vx_coef
    import vx_pkg::*;
(
    input  xf_mode_e          mode_i,
    input  logic [STEP_W-1:0] step_i,
    input  coef_t             sin_i,
    input  coef_t             cos_i,
    output coef_t             coef_o
);
    // Even steps weight operand 0, odd steps weight operand 1;
    // step pair j produces result j.
    always_comb begin
        coef_o = '0;
        case (mode_i)
            XF_CLARKE_FWD: begin
                case (step_i)
                    3'd0:    coef_o = K_UNIT;
                    3'd2:    coef_o = K_INV_RT3;
                    3'd3:    coef_o = K_2INV_RT3;
                    default: coef_o = '0;
                endcase
            end
            XF_CLARKE_REV: begin
                case (step_i)
                    3'd0:    coef_o = K_UNIT;
                    3'd2:    coef_o = -K_HALF;
                    3'd3:    coef_o = K_RT3_HALF;
                    3'd4:    coef_o = -K_HALF;
                    3'd5:    coef_o = -K_RT3_HALF;
                    default: coef_o = '0;
                endcase
            end
            XF_PARK_FWD: begin
                case (step_i)
                    3'd0:    coef_o = cos_i;
                    3'd1:    coef_o = sin_i;
                    3'd2:    coef_o = -sin_i;
                    3'd3:    coef_o = cos_i;
                    default: coef_o = '0;
                endcase
            end
            XF_PARK_REV: begin
                case (step_i)
                    3'd0:    coef_o = cos_i;
                    3'd1:    coef_o = -sin_i;
                    3'd2:    coef_o = sin_i;
                    3'd3:    coef_o = cos_i;
                    default: coef_o = '0;
                endcase
            end
            default: coef_o = '0;
        endcase
    end
endmodule

// File: rtl/vx_mac.sv
module vx_mac #(
    parameter int DW   = 12,
    parameter int CW   = 13,
    parameter int FRAC = 11
) (
    input  logic signed [DW+CW:0]   acc_i,
    input  logic signed [DW-1:0]    x_i,
    input  logic signed [CW-1:0]    k_i,
    input  logic                    first_i,
    output logic signed [DW+CW:0]   sum_o,
    output logic signed [DW-1:0]    res_o
);
    localparam int PW = DW + CW;
    localparam int SW = PW + 1;
    localparam logic signed [SW:0] SMAX = (SW+1)'((1 << (DW-1)) - 1);
    localparam logic signed [SW:0] SMIN = -SMAX - 1;
    localparam logic [SW:0]        HALF = (SW+1)'(1 << (FRAC-1));

    logic signed [PW-1:0] prod;
    logic signed [SW:0]   rnd;
    logic signed [SW:0]   shf;

    always_comb begin
        prod  = x_i * k_i;
        sum_o = (first_i ? '0 : acc_i) + {prod[PW-1], prod};
        rnd   = {sum_o[SW-1], sum_o} + HALF;
        shf   = rnd >>> FRAC;
        if (shf > SMAX)      res_o = SMAX[DW-1:0];
        else if (shf < SMIN) res_o = SMIN[DW-1:0];
        else                 res_o = shf[DW-1:0];
    end
endmodule

// File: rtl/vx_xform.sv
module vx_xform
    import vx_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [1:0]           mode_i,
    input  logic signed [DW-1:0] op0_i,
    input  logic signed [DW-1:0] op1_i,
    input  logic [AW-1:0]        angle_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic signed [DW-1:0] res0_o,
    output logic signed [DW-1:0] res1_o,
    output logic signed [DW-1:0] res2_o
);
    localparam int SW   = DW + CW + 1;
    localparam int LAST = NSTEP - 1;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic [STEP_W-1:0]     step;
        xf_mode_e              mode;
        logic [ANG_IDX_W-1:0]  aidx;
        logic signed [DW-1:0]  in0;
        logic signed [DW-1:0]  in1;
        logic signed [SW-1:0]  acc;
        logic signed [DW-1:0]  stg0;
        logic signed [DW-1:0]  stg1;
        logic signed [DW-1:0]  r0;
        logic signed [DW-1:0]  r1;
        logic signed [DW-1:0]  r2;
    } st_t;

    st_t st_q, st_d;

    coef_t                sin_w, cos_w, coef_w;
    logic signed [SW-1:0] sum_w;
    logic signed [DW-1:0] rs_w;
    logic signed [DW-1:0] opnd_w;
    logic [1:0]           outsel_w;
    logic                 unused_angle_lsb;

    assign unused_angle_lsb = ^angle_i[AW-ANG_IDX_W-1:0];
    assign opnd_w   = st_q.step[0] ? st_q.in1 : st_q.in0;
    assign outsel_w = st_q.step[STEP_W-1:1];

    vx_sincos u_sincos (
        .idx_i (st_q.aidx),
        .sin_o (sin_w),
        .cos_o (cos_w)
    );

    vx_coef u_coef (
        .mode_i (st_q.mode),
        .step_i (st_q.step),
        .sin_i  (sin_w),
        .cos_i  (cos_w),
        .coef_o (coef_w)
    );

    vx_mac #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
        .acc_i   (st_q.acc),
        .x_i     (opnd_w),
        .k_i     (coef_w),
        .first_i (~st_q.step[0]),
        .sum_o   (sum_w),
        .res_o   (rs_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.mode = xf_mode_e'(mode_i);
                st_d.aidx = angle_i[AW-1 -: ANG_IDX_W];
                st_d.in0  = op0_i;
                st_d.in1  = op1_i;
            end
        end else begin
            st_d.acc = sum_w;
            if (st_q.step[0]) begin
                case (outsel_w)
                    2'd0:    st_d.stg0 = rs_w;
                    2'd1:    st_d.stg1 = rs_w;
                    default: ;
                endcase
            end
            if (st_q.step == STEP_W'(LAST)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.r0   = st_q.stg0;
                st_d.r1   = st_q.stg1;
                st_d.r2   = rs_w;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign res0_o = st_q.r0;
    assign res1_o = st_q.r1;
    assign res2_o = st_q.r2;
endmodule

// File: rtl/vx_xform_chk.sv
module vx_xform_chk #(
    parameter int DW = 12
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 start_i,
    input logic [1:0]           mode_i,
    input logic signed [DW-1:0] op0_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic signed [DW-1:0] res0_o,
    input logic signed [DW-1:0] res1_o,
    input logic signed [DW-1:0] res2_o
);
    logic [3:0]           cnt_q;
    logic [1:0]           m_q;
    logic signed [DW-1:0] a_q;
    logic                 acc_ev;

    assign acc_ev = start_i && !busy_o;

    // Edge counter since the last accepted start (1 after accept edge)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            m_q   <= '0;
            a_q   <= '0;
        end else if (acc_ev) begin
            cnt_q <= 4'd1;
            m_q   <= mode_i;
            a_q   <= op0_i;
        end else if (cnt_q == 4'd7) begin
            cnt_q <= '0;
        end else if (cnt_q != 4'd0) begin
            cnt_q <= cnt_q + 4'd1;
        end
    end

    p_done_late_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cnt_q == 4'd7));
    p_done_due_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == 4'd7) |-> done_o);
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable({res0_o, res1_o, res2_o}));
    p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_ev |=> busy_o);
    p_busy_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (cnt_q >= 4'd1 && cnt_q <= 4'd6));
    p_clarke_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && m_q == 2'd0) |-> (res0_o == a_q && res2_o == '0));
    p_clarke_rev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && m_q == 2'd1) |-> (res0_o == a_q));
    // Covers both rotation directions (R5 and R6)
    p_park_third_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && m_q[1]) |-> (res2_o == '0));
endmodule

bind vx_xform vx_xform_chk #(.DW(DW)) u_vx_xform_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .op0_i   (op0_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .res0_o  (res0_o),
    .res1_o  (res1_o),
    .res2_o  (res2_o)
);

// File: tb/vx_xform_bench.sv
module vx_xform_bench;
    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         mode = '0;
    logic signed [11:0] op0 = '0;
    logic signed [11:0] op1 = '0;
    logic [11:0]        angle = '0;
    logic               busy, done;
    logic signed [11:0] res0, res1, res2;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vx_xform u_vx_xform (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .mode_i (mode),
        .op0_i (op0), .op1_i (op1), .angle_i (angle),
        .busy_o (busy), .done_o (done),
        .res0_o (res0), .res1_o (res1), .res2_o (res2)
    );

    task automatic check(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rs(input longint p);
        longint t;
        t = (p + 64'sd1024) >>> 11;
        if (t > 2047)  return 2047;
        if (t < -2048) return -2048;
        return int'(t);
    endfunction

    function automatic longint qtrig(input int n, input bit want_cos);
        real v;
        v = (want_cos ? $cos(n * PI / 32.0) : $sin(n * PI / 32.0)) * 2047.0;
        if (v >= 0.0) return longint'($floor(v + 0.5));
        return -longint'($floor(-v + 0.5));
    endfunction

    task automatic model(input logic [1:0] m, input int x, input int y,
                         input logic [11:0] ang,
                         output int e0, output int e1, output int e2);
        longint lx, ly, c, s;
        lx = x; ly = y;
        c = qtrig(int'(ang >> 6), 1'b1);
        s = qtrig(int'(ang >> 6), 1'b0);
        e2 = 0;
        case (m)
            2'd0: begin e0 = rs(2048*lx); e1 = rs(1182*lx + 2364*ly); end
            2'd1: begin
                e0 = rs(2048*lx);
                e1 = rs(-1024*lx + 1774*ly);
                e2 = rs(-1024*lx - 1774*ly);
            end
            2'd2: begin e0 = rs(lx*c + ly*s); e1 = rs(-lx*s + ly*c); end
            default: begin e0 = rs(lx*c - ly*s); e1 = rs(lx*s + ly*c); end
        endcase
    endtask

    // Returns number of rising edges from the accepting edge to done
    task automatic run_op(input logic [1:0] m, input int x, input int y,
                          input logic [11:0] ang, output int lat);
        @(negedge clk);
        mode = m; op0 = 12'(x); op1 = 12'(y); angle = ang; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic do_vec(input string tag, input logic [1:0] m,
                          input int x, input int y, input logic [11:0] ang);
        int lat, e0, e1, e2;
        run_op(m, x, y, ang, lat);
        model(m, x, y, ang, e0, e1, e2);
        check({tag, " R8 latency"}, lat, 7);
        check({tag, " res0"}, int'(res0), e0);
        check({tag, " res1"}, int'(res1), e1);
        check({tag, " res2"}, int'(res2), e2);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            nerr++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int pulses, lat, e0, e1, e2;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 res0", int'(res0), 0);
        check("R10 res1", int'(res1), 0);
        check("R10 res2", int'(res2), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R7: Clarke grid covering both rails
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                do_vec("R2 fwd-clarke", 2'd0, -2048 + i*273, -2048 + j*273, 12'h000);
                do_vec("R3 rev-clarke", 2'd1, -2048 + i*273, -2048 + j*273, 12'h000);
            end
        end

        // R4 R5 R6 R7: every angle step, junk in the ignored low bits
        for (int n = 0; n < 64; n++) begin
            for (int p = 0; p < 6; p++) begin
                int x, y;
                logic [11:0] ang;
                ang = 12'((n << 6) | ((n * 37 + p * 11) & 63));
                case (p)
                    0: begin x = 2047;  y = 0;     end
                    1: begin x = 0;     y = 2047;  end
                    2: begin x = -2048; y = -2048; end
                    3: begin x = 1000;  y = -1500; end
                    4: begin x = -7;    y = 13;    end
                    default: begin x = 2047; y = 2047; end
                endcase
                do_vec("R5 R4 fwd-park", 2'd2, x, y, ang);
                do_vec("R6 R4 rev-park", 2'd3, x, y, ang);
            end
        end

        // R7: saturation spot checks
        do_vec("R7 sat-high", 2'd0, 2047, 2047, 12'h000);
        do_vec("R7 sat-low", 2'd2, -2048, -2048, 12'h200);

        // R9: start while busy has no effect
        @(negedge clk);
        mode = 2'd2; op0 = 12'sd1000; op1 = -12'sd1500; angle = 12'h2A5; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 40) begin
            if (lat >= 2 && lat <= 4) begin
                start = 1'b1; mode = 2'd1; op0 = -12'sd2000; op1 = 12'sd2000; angle = 12'h000;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 1'b0;
        model(2'd2, 1000, -1500, 12'h2A5, e0, e1, e2);
        check("R9 latency under busy start", lat, 7);
        check("R9 res0 kept", int'(res0), e0);
        check("R9 res1 kept", int'(res1), e1);
        check("R9 res2 kept", int'(res2), e2);
        pulses = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done || busy) pulses++;
        end
        check("R9 no deferred start", pulses, 0);
        check("R9 res0 unchanged", int'(res0), e0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule